// File: doc/BRIEF.md
# LNB Supply Controller I2C Register Target

This block is the serial control port of a satellite-antenna supply controller. It listens on a two-wire I2C bus as a target. The bus lines are sampled through synchronisers clocked by the chip clock, and START and STOP conditions are found from the synchronised levels. A strap input picks one of two 7-bit addresses. A write transfer carries a register pointer followed by data bytes that land in consecutive registers. A read transfer returns bytes from the pointer onwards, and the pointer moves up each time the master acknowledges.

Six registers sit behind the pointer. Two are read-only status registers: the first reports the overload, over-temperature and low-supply flags, and the second always reads zero. Four are control registers that drive the output-voltage code, the tone enable, the tone source select, the static current-limit select and the two latch-off selects. The block sends a one-cycle strobe to the fault logic whenever it loads the first status register for sending, so that the fault logic can clear its latched flags on read. The fault logic can also clear the voltage-select field directly. While the undervoltage lockout input is high, the target stays off the bus and holds every control register at zero.

Top module: `lnb_i2c_target`

## Requirements
- R1: After reset, every control output is 0 and `sda_oe_o` is 0.
- R2: The target acknowledges only address 7'b0001000 when `addr_strap_i` is 0, and only 7'b0001001 when it is 1. The address is the 7 MSBs of the first byte after START, and bit 0 is R/W, with 1 meaning read. A transfer to any other address gets no acknowledge and changes no register.
- R3: A write transfer is address (R/W=0), pointer byte, then data bytes. The target acknowledges each byte by driving SDA low during the ninth clock. Data byte k goes to register pointer+k. The target changes `sda_oe_o` only while SCL is low.
- R4: A read transfer (R/W=1) returns the register at the pointer, MSB first. The pointer advances after each byte, and a further byte follows each master ACK. A master NACK ends the transfer with SDA released.
- R5: Register 0x0 reads {`flag_low_i`, `flag_hot_i`, 5'b0, `flag_ovl_i`} (bit 7 down to bit 0). Register 0x1 reads 0x00.
- R6: The control registers at 0x2..0x5 read back the last written value ANDed with the masks 0x0F, 0x05, 0x04 and 0x48. Outputs: `volt_sel_o`=reg2[3:0], `tone_en_o`=reg3[0], `tone_ext_o`=reg3[2], `static_limit_o`=reg4[2], `ovl_latch_off_o`=reg5[3], `hot_latch_off_o`=reg5[6].
- R7: `stat_rd_o` pulses high for exactly one cycle each time register 0x0 is loaded for sending, and at no other time.
- R8: While `lockout_i` is high, the target never acknowledges, and from the next cycle on all control registers are zero.
- R9: A high on `volt_clr_i` clears `volt_sel_o` in the next cycle, even if a write to 0x2 happens in the same cycle. Other control bits are left unchanged.
- R10: A STOP or a START at any point returns the target to address reception. A repeated START after a pointer write can be followed directly by a read.
- R11: Pointers above 0x5 read as 0x00, and writes to them are acknowledged but change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| addr_strap_i | input | 1 | Selects the address LSB |
| lockout_i | input | 1 | Undervoltage lockout, synchronous |
| flag_ovl_i | input | 1 | Latched overload flag |
| flag_hot_i | input | 1 | Latched over-temperature flag |
| flag_low_i | input | 1 | Latched low-supply flag |
| volt_clr_i | input | 1 | Clears the voltage-select field |
| stat_rd_o | output | 1 | Status register 0x0 read strobe |
| volt_sel_o | output | 4 | Output voltage code |
| tone_en_o | output | 1 | Tone enable |
| tone_ext_o | output | 1 | Tone source: 1 external carrier, 0 envelope |
| static_limit_o | output | 1 | 1 selects static current limit |
| ovl_latch_off_o | output | 1 | 1 latches the output off after overload |
| hot_latch_off_o | output | 1 | 1 latches the output off after over-temperature |

## Verification
A bit counter or phase register that slips shows up at the ninth clock of the same byte. The acknowledge is then missing or misplaced, and a read byte comes out shifted. The bench catches this when it samples that clock. A wrong pointer value shows up in the next data byte as a value in the wrong register, and a readback within one transfer exposes it. Mask, clear and lockout faults show up on the control outputs one cycle after the cause. The bench checks these outputs after each transfer or pulse.

// File: rtl/lnb_i2c_pkg.sv
package lnb_i2c_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned AW       = 8;
  localparam int unsigned NUM_CTRL = 4;
  localparam int unsigned BIT_CW   = $clog2(DW + 1);

  localparam logic [AW-1:0] ST1_ADDR  = 8'h00;
  localparam logic [AW-1:0] ST2_ADDR  = 8'h01;
  localparam logic [AW-1:0] CTRL_BASE = 8'h02;
  localparam logic [6:0]    DEV_BASE  = 7'b0001000;
  localparam logic [DW-1:0] VOLT_FIELD = 8'h0F;

  typedef enum logic [3:0] {
    PH_IDLE, PH_ADDR, PH_ADDR_ACK, PH_PTR, PH_PTR_ACK,
    PH_WDATA, PH_WDATA_ACK, PH_RDATA, PH_RACK
  } phase_e;

  function automatic logic [DW-1:0] ctrl_mask(input int idx);
    case (idx)
      0:       return 8'h0F;
      1:       return 8'h05;
      2:       return 8'h04;
      3:       return 8'h48;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import lnb_i2c_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_lvl_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_lvl_i,
  input  logic          sda_rise_i,
  input  logic          sda_fall_i,
  input  logic [6:0]    dev_addr_i,
  input  logic          lockout_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          stat_rd_o,
  output logic          sda_oe_o
);
  phase_e            ph_q;
  logic [BIT_CW-1:0] cnt_q;
  logic [DW-1:0]     sh_q, tx_q, wdata_q;
  logic [AW-1:0]     ptr_q, waddr_q;
  logic              rw_q, mack_q, oe_q, wen_q, stb_q;

  logic start_c, stop_c, byte_end_c;
  assign start_c    = scl_lvl_i & sda_fall_i;
  assign stop_c     = scl_lvl_i & sda_rise_i;
  assign byte_end_c = scl_fall_i && (cnt_q == BIT_CW'(DW));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      ptr_q   <= '0;
      waddr_q <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      wen_q   <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      wen_q <= 1'b0;
      stb_q <= 1'b0;
      if (lockout_i) begin
        ph_q <= PH_IDLE;
        oe_q <= 1'b0;
      end else if (start_c) begin
        ph_q  <= PH_ADDR;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (stop_c) begin
        ph_q <= PH_IDLE;
        oe_q <= 1'b0;
      end else begin
        case (ph_q)
          PH_ADDR, PH_PTR, PH_WDATA: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[DW-2:0], sda_lvl_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (byte_end_c) begin
              cnt_q <= '0;
              if (ph_q == PH_ADDR) begin
                if (sh_q[DW-1:1] == dev_addr_i) begin
                  rw_q <= sh_q[0];
                  oe_q <= 1'b1;
                  ph_q <= PH_ADDR_ACK;
                end else begin
                  ph_q <= PH_IDLE;
                end
              end else if (ph_q == PH_PTR) begin
                ptr_q <= sh_q;
                oe_q  <= 1'b1;
                ph_q  <= PH_PTR_ACK;
              end else begin
                wen_q   <= 1'b1;
                waddr_q <= ptr_q;
                wdata_q <= sh_q;
                ptr_q   <= ptr_q + 1'b1;
                oe_q    <= 1'b1;
                ph_q    <= PH_WDATA_ACK;
              end
            end
          end
          PH_ADDR_ACK: begin
            if (scl_fall_i) begin
              if (rw_q) begin
                tx_q  <= rd_data_i;
                oe_q  <= ~rd_data_i[DW-1];
                stb_q <= (ptr_q == ST1_ADDR);
                ptr_q <= ptr_q + 1'b1;
                ph_q  <= PH_RDATA;
              end else begin
                oe_q <= 1'b0;
                ph_q <= PH_PTR;
              end
            end
          end
          PH_PTR_ACK, PH_WDATA_ACK: begin
            if (scl_fall_i) begin
              oe_q <= 1'b0;
              ph_q <= PH_WDATA;
            end
          end
          PH_RDATA: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (byte_end_c) begin
              cnt_q <= '0;
              oe_q  <= 1'b0;
              ph_q  <= PH_RACK;
            end else if (scl_fall_i) begin
              tx_q <= {tx_q[DW-2:0], 1'b0};
              oe_q <= ~tx_q[DW-2];
            end
          end
          PH_RACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_lvl_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                tx_q  <= rd_data_i;
                oe_q  <= ~rd_data_i[DW-1];
                stb_q <= (ptr_q == ST1_ADDR);
                ptr_q <= ptr_q + 1'b1;
                ph_q  <= PH_RDATA;
              end else begin
                ph_q <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr_o = ptr_q;
  assign wr_en_o   = wen_q;
  assign wr_addr_o = waddr_q;
  assign wr_data_o = wdata_q;
  assign stat_rd_o = stb_q;
  assign sda_oe_o  = oe_q;
endmodule

// File: rtl/lnb_reg_file.sv
module lnb_reg_file
  import lnb_i2c_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         lockout_i,
  input  logic                         volt_clr_i,
  input  logic                         wr_en_i,
  input  logic [AW-1:0]                wr_addr_i,
  input  logic [DW-1:0]                wr_data_i,
  input  logic [AW-1:0]                rd_addr_i,
  input  logic [DW-1:0]                status_i,
  output logic [DW-1:0]                rd_data_o,
  output logic [NUM_CTRL-1:0][DW-1:0]  ctrl_o
);
  logic [NUM_CTRL-1:0][DW-1:0] ctrl_q;

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
    localparam logic [AW-1:0] MY_ADDR = AW'(int'(CTRL_BASE) + i);
    localparam logic [DW-1:0] MASK    = ctrl_mask(i);
    localparam logic [DW-1:0] CLR     = (i == 0) ? VOLT_FIELD : '0;
    logic [DW-1:0] nxt;

    always_comb begin
      nxt = ctrl_q[i];
      if (wr_en_i && (wr_addr_i == MY_ADDR)) nxt = wr_data_i & MASK;
      if (volt_clr_i) nxt = nxt & ~CLR;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        ctrl_q[i] <= '0;
      else if (lockout_i) ctrl_q[i] <= '0;
      else                ctrl_q[i] <= nxt;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ST1_ADDR) rd_data_o = status_i;
    else if (rd_addr_i == ST2_ADDR) rd_data_o = '0;
    for (int i = 0; i < NUM_CTRL; i++) begin
      if (rd_addr_i == AW'(int'(CTRL_BASE) + i)) rd_data_o = ctrl_q[i];
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/lnb_i2c_target.sv
module lnb_i2c_target
  import lnb_i2c_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       addr_strap_i,
  input  logic       lockout_i,
  input  logic       flag_ovl_i,
  input  logic       flag_hot_i,
  input  logic       flag_low_i,
  input  logic       volt_clr_i,
  output logic       stat_rd_o,
  output logic [3:0] volt_sel_o,
  output logic       tone_en_o,
  output logic       tone_ext_o,
  output logic       static_limit_o,
  output logic       ovl_latch_off_o,
  output logic       hot_latch_off_o
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] raw, lvl, rise, fall;
  assign raw = {sda_i, scl_i};

  for (genvar l = 0; l < NLINES; l++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[l]),
      .lvl_o  (lvl[l]),
      .rise_o (rise[l]),
      .fall_o (fall[l])
    );
  end

  logic [AW-1:0]               rd_addr, wr_addr;
  logic [DW-1:0]               rd_data, wr_data, status1;
  logic                        wr_en;
  logic [NUM_CTRL-1:0][DW-1:0] ctrl;

  assign status1 = {flag_low_i, flag_hot_i, 5'b0, flag_ovl_i};

  i2c_byte_engine u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_lvl_i  (lvl[0]),
    .scl_rise_i (rise[0]),
    .scl_fall_i (fall[0]),
    .sda_lvl_i  (lvl[1]),
    .sda_rise_i (rise[1]),
    .sda_fall_i (fall[1]),
    .dev_addr_i ({DEV_BASE[6:1], addr_strap_i}),
    .lockout_i  (lockout_i),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .stat_rd_o  (stat_rd_o),
    .sda_oe_o   (sda_oe_o)
  );

  lnb_reg_file u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lockout_i  (lockout_i),
    .volt_clr_i (volt_clr_i),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .status_i   (status1),
    .rd_data_o  (rd_data),
    .ctrl_o     (ctrl)
  );

  assign volt_sel_o      = ctrl[0][3:0];
  assign tone_en_o       = ctrl[1][0];
  assign tone_ext_o      = ctrl[1][2];
  assign static_limit_o  = ctrl[2][2];
  assign ovl_latch_off_o = ctrl[3][3];
  assign hot_latch_off_o = ctrl[3][6];
endmodule

// File: rtl/lnb_i2c_target_chk.sv
module lnb_i2c_target_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic       lockout_i,
  input logic       volt_clr_i,
  input logic       stat_rd_o,
  input logic [3:0] volt_sel_o,
  input logic       tone_en_o,
  input logic       tone_ext_o,
  input logic       static_limit_o,
  input logic       ovl_latch_off_o,
  input logic       hot_latch_off_o
);
  // R8
  lockout_ctrl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_i |=> (volt_sel_o == 4'd0 && !tone_en_o && !tone_ext_o &&
                   !static_limit_o && !ovl_latch_off_o && !hot_latch_off_o));

  // R8
  lockout_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_i |=> !sda_oe_o);

  // R9
  volt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    volt_clr_i |=> (volt_sel_o == 4'd0));

  // R7
  stat_strobe_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_o |=> !stat_rd_o);

  // R3
  sda_change_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(lockout_i) && (sda_oe_o != $past(sda_oe_o))) |-> !scl_i);
endmodule

bind lnb_i2c_target lnb_i2c_target_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .scl_i           (scl_i),
  .sda_oe_o        (sda_oe_o),
  .lockout_i       (lockout_i),
  .volt_clr_i      (volt_clr_i),
  .stat_rd_o       (stat_rd_o),
  .volt_sel_o      (volt_sel_o),
  .tone_en_o       (tone_en_o),
  .tone_ext_o      (tone_ext_o),
  .static_limit_o  (static_limit_o),
  .ovl_latch_off_o (ovl_latch_off_o),
  .hot_latch_off_o (hot_latch_off_o)
);

// File: tb/lnb_i2c_target_bench.sv
module lnb_i2c_target_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_strap = 1'b0, lockout = 1'b0, volt_clr = 1'b0;
  logic f_ovl = 1'b0, f_hot = 1'b0, f_low = 1'b0;
  logic sda_oe, stat_rd;
  logic [3:0] volt_sel;
  logic tone_en, tone_ext, static_lim, ovl_off, hot_off;
  logic sda_line;
  int   n_run = 0, n_fail = 0, stat_pulses = 0, cyc = 0;
  logic ack;
  logic [7:0] rb;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  lnb_i2c_target u_lnb_i2c_target (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_strap_i(addr_strap), .lockout_i(lockout),
    .flag_ovl_i(f_ovl), .flag_hot_i(f_hot), .flag_low_i(f_low),
    .volt_clr_i(volt_clr), .stat_rd_o(stat_rd), .volt_sel_o(volt_sel),
    .tone_en_o(tone_en), .tone_ext_o(tone_ext), .static_limit_o(static_lim),
    .ovl_latch_off_o(ovl_off), .hot_latch_off_o(hot_off)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (stat_rd) stat_pulses <= stat_pulses + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); a = ~sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic rx_byte(input logic give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); d[i] = sda_line; wq(); scl_m = 1'b0; wq();
    end
    sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [6:0] dev, input logic [7:0] p);
    i2c_start();
    tx_byte({dev, 1'b0}, ack); chk("R2 addr ack", ack, 1);
    tx_byte(p, ack);           chk("R3 ptr ack", ack, 1);
    i2c_stop();
  endtask

  task automatic t_reset();
    chk("R1 volt_sel", volt_sel, 0);
    chk("R1 ctrl bits", {tone_en, tone_ext, static_lim, ovl_off, hot_off}, 0);
    chk("R1 sda_oe", sda_oe, 0);
  endtask

  task automatic t_write_burst();
    i2c_start();
    tx_byte(8'h10, ack); chk("R2 addr ack", ack, 1);
    tx_byte(8'h02, ack); chk("R3 ptr ack", ack, 1);
    tx_byte(8'h0A, ack); chk("R3 data ack", ack, 1);
    tx_byte(8'h05, ack); chk("R3 data ack", ack, 1);
    tx_byte(8'h04, ack); chk("R3 data ack", ack, 1);
    tx_byte(8'h48, ack); chk("R3 data ack", ack, 1);
    i2c_stop();
    chk("R3 volt_sel", volt_sel, 4'hA);
    chk("R6 tone bits", {tone_en, tone_ext}, 2'b11);
    chk("R6 limit/latch", {static_lim, ovl_off, hot_off}, 3'b111);
  endtask

  task automatic t_read_burst(input logic [7:0] e0, e1, e2, e3, input string req);
    set_ptr(7'h08, 8'h02);
    i2c_start();
    tx_byte(8'h11, ack); chk("R4 read addr ack", ack, 1);
    rx_byte(1'b1, rb); chk(req, rb, e0);
    rx_byte(1'b1, rb); chk(req, rb, e1);
    rx_byte(1'b1, rb); chk(req, rb, e2);
    rx_byte(1'b0, rb); chk(req, rb, e3);
    chk("R4 released after nack", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic t_reserved();
    i2c_start();
    tx_byte(8'h10, ack); tx_byte(8'h02, ack);
    for (int i = 0; i < 4; i++) tx_byte(8'hFF, ack);
    i2c_stop();
    t_read_burst(8'h0F, 8'h05, 8'h04, 8'h48, "R6 masked readback");
  endtask

  task automatic t_address();
    i2c_start();
    tx_byte(8'h12, ack); chk("R2 foreign addr nack", ack, 0);
    tx_byte(8'h02, ack); tx_byte(8'h00, ack);
    i2c_stop();
    chk("R2 foreign no effect", volt_sel, 4'hF);
    addr_strap = 1'b1; wq();
    i2c_start();
    tx_byte(8'h10, ack); chk("R2 strap high rejects 0x08", ack, 0);
    i2c_stop();
    i2c_start();
    tx_byte(8'h12, ack); chk("R2 strap high ack 0x09", ack, 1);
    tx_byte(8'h02, ack); tx_byte(8'h03, ack);
    i2c_stop();
    chk("R2 strap write", volt_sel, 4'h3);
    addr_strap = 1'b0; wq();
  endtask

  task automatic t_status();
    int p0;
    f_ovl = 1'b1; f_hot = 1'b0; f_low = 1'b1;
    set_ptr(7'h08, 8'h00);
    p0 = stat_pulses;
    i2c_start();
    tx_byte(8'h11, ack);
    rx_byte(1'b1, rb); chk("R5 status1", rb, 8'h81);
    rx_byte(1'b0, rb); chk("R5 status2", rb, 8'h00);
    i2c_stop();
    chk("R7 one strobe", stat_pulses - p0, 1);
    f_ovl = 1'b0; f_hot = 1'b1; f_low = 1'b0;
    set_ptr(7'h08, 8'h01);
    p0 = stat_pulses;
    i2c_start();
    tx_byte(8'h11, ack);
    rx_byte(1'b0, rb); chk("R5 status2 only", rb, 8'h00);
    i2c_stop();
    chk("R7 no strobe for 0x1", stat_pulses - p0, 0);
    set_ptr(7'h08, 8'h00);
    i2c_start();
    tx_byte(8'h11, ack);
    rx_byte(1'b0, rb); chk("R5 status1 hot", rb, 8'h40);
    i2c_stop();
    f_hot = 1'b0;
  endtask

  task automatic t_out_of_range();
    i2c_start();
    tx_byte(8'h10, ack); tx_byte(8'h06, ack);
    tx_byte(8'hFF, ack); chk("R11 write acked", ack, 1);
    i2c_stop();
    chk("R11 no effect", {volt_sel, tone_en, tone_ext, static_lim, ovl_off, hot_off}, 9'h07F);
    set_ptr(7'h08, 8'h06);
    i2c_start();
    tx_byte(8'h11, ack);
    rx_byte(1'b0, rb); chk("R11 reads zero", rb, 8'h00);
    i2c_stop();
  endtask

  task automatic t_volt_clear();
    i2c_start();
    tx_byte(8'h10, ack); tx_byte(8'h02, ack); tx_byte(8'h0C, ack);
    i2c_stop();
    chk("R9 preset", volt_sel, 4'hC);
    volt_clr = 1'b1; @(negedge clk); volt_clr = 1'b0; @(negedge clk);
    chk("R9 cleared", volt_sel, 0);
    chk("R9 others kept", {tone_en, tone_ext, static_lim}, 3'b111);
  endtask

  task automatic t_lockout();
    lockout = 1'b1; repeat (3) @(negedge clk);
    chk("R8 ctrl zero", {volt_sel, tone_en, tone_ext, static_lim, ovl_off, hot_off}, 0);
    i2c_start();
    tx_byte(8'h10, ack); chk("R8 no ack", ack, 0);
    tx_byte(8'h02, ack); tx_byte(8'h0F, ack);
    i2c_stop();
    chk("R8 still zero", volt_sel, 0);
    lockout = 1'b0; wq();
    set_ptr(7'h08, 8'h02);
    i2c_start();
    tx_byte(8'h11, ack);
    rx_byte(1'b0, rb); chk("R8 readback zero", rb, 8'h00);
    i2c_stop();
  endtask

  task automatic t_restart();
    i2c_start();
    tx_byte(8'h10, ack); tx_byte(8'h03, ack); tx_byte(8'h05, ack);
    i2c_stop();
    // abort mid-byte with a STOP, then a clean transfer must work
    i2c_start();
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    i2c_stop();
    i2c_start();
    tx_byte(8'h10, ack); chk("R10 after abort ack", ack, 1);
    tx_byte(8'h03, ack);
    i2c_start();
    tx_byte(8'h11, ack); chk("R10 restart read ack", ack, 1);
    rx_byte(1'b0, rb); chk("R10 restart read data", rb, 8'h05);
    i2c_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_burst();
    t_read_burst(8'h0A, 8'h05, 8'h04, 8'h48, "R4 burst readback");
    t_reserved();
    t_address();
    t_status();
    t_out_of_range();
    t_volt_clear();
    t_lockout();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule